// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-facing register file of one descriptor-driven DMA channel. A host reads and writes aligned 32-bit words at byte offsets 0x00 through 0x20. The block keeps three writable registers: the control/status word, the descriptor pointer and a free-form debug word. It also shows read-only copies of the six descriptor fields that the transfer engine has loaded.

The control/status word holds three kinds of bit side by side. Some are stored plainly through a fixed write mask. The completion and interrupt flags are cleared by writing a one to them. Two command bits take effect on the write and are never stored: a reset that clears itself, and an abort. When a write moves the active bit from 0 to 1, the block sends a one-cycle start pulse to the transfer engine. The engine reports back through two set inputs, one for completion and one for interrupt. The interrupt flag drives the channel's interrupt line directly.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every defined offset reads zero, `irqOut` is low and `startPulse` is low.
- R2: Completion flag (control/status bit 1): `engDone` sets it. Writing control/status with bit 1 = 1 clears it. Writing 0 to bit 1 leaves it unchanged.
- R3: Interrupt flag (control/status bit 2): `engIntSet` sets it and raises `irqOut`. Writing control/status with bit 2 = 1 clears the flag and drops `irqOut`. Writing 0 to bit 2 leaves both unchanged.
- R4: A control/status write with bit 31 = 1 zeroes the control/status word and the descriptor pointer (offset 0x04) first. The masked bits of the same write are then stored. Bit 31 itself is never stored.
- R5: A control/status write stores only the bits of mask 0x30FF0001 (bit 0 is active). All other bits keep their value. Bits 4, 5 and 8 always read zero. Bit 30 (abort) has no effect and is not stored.
- R6: `startPulse` is high for exactly one cycle, in the cycle after a control/status write that finds bit 0 at 0 and writes it to 1. No other write raises it.
- R7: A read of an unaligned offset, or of any offset above 0x20, returns zero. A write to such an offset changes no register.
- R8: When `engDone` or `engIntSet` arrives in the same cycle as a software clear of the same flag, the flag ends up set.
- R9: While `descLoad` is high, the descriptor inputs are captured. They read back at 0x08 (info), 0x0C (source), 0x10 (destination), 0x14 (length), 0x18 (stride) and 0x1C (next). Writes to these offsets are ignored.
- R10: The descriptor pointer at 0x04 and the debug word at 0x20 store all 32 bits written and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Byte offset for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| descLoad | input | 1 | Capture the descriptor inputs |
| descInfo | input | 32 | Descriptor transfer-information word |
| descSrc | input | 32 | Descriptor source address |
| descDst | input | 32 | Descriptor destination address |
| descLen | input | 32 | Descriptor transfer length |
| descStride | input | 32 | Descriptor stride word |
| descNext | input | 32 | Descriptor next pointer |
| engDone | input | 1 | Engine sets the completion flag |
| engIntSet | input | 1 | Engine sets the interrupt flag |
| startPulse | output | 1 | One-cycle start request to the engine |
| irqOut | output | 1 | Channel interrupt line |

## Verification
The assertions assume that `wrEn`, `engDone`, `engIntSet` and `descLoad` are single-cycle strobes sampled on the rising edge. They also assume that `addr` and `wrData` are stable around that edge.

The bench drives every input on the falling edge. It holds each strobe for one cycle and samples outputs on the falling edge after the write's rising edge, so every check lands in a known cycle. Where the engine's set inputs collide with a software clear, the bench drives both in the same cycle on purpose.

// File: rtl/dma_chan_csr_pkg.sv
package dma_chan_csr_pkg;

  localparam int DATA_W = 32;
  localparam int DESC_WORDS = 6;

  // Control/status bit positions (software-visible encoding)
  localparam int BIT_ACTIVE = 0;
  localparam int BIT_END    = 1;
  localparam int BIT_INT    = 2;
  localparam int BIT_ABORT  = 30;
  localparam int BIT_RESET  = 31;

  localparam logic [DATA_W-1:0] CS_STORE_MASK = 32'h30FF_0001;
  localparam logic [DATA_W-1:0] CS_FLAG_MASK  = 32'h0000_0006;

  // Order follows the word offsets: index = (offset >> 2) + 1
  typedef enum logic [3:0] {
    SEL_NONE   = 4'd0,
    SEL_CS     = 4'd1,
    SEL_DADDR  = 4'd2,
    SEL_INFO   = 4'd3,
    SEL_SRC    = 4'd4,
    SEL_DST    = 4'd5,
    SEL_LEN    = 4'd6,
    SEL_STRIDE = 4'd7,
    SEL_NEXT   = 4'd8,
    SEL_DEBUG  = 4'd9
  } regSel_e;

  localparam int NUM_WORDS = 9;

  typedef struct packed {
    logic    wrCs;
    logic    wrDescAddr;
    logic    wrDebug;
    regSel_e rdSel;
  } csrStb_t;

endpackage

// File: rtl/dma_chan_csr_ctrl.sv
module dma_chan_csr_ctrl
  import dma_chan_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output csrStb_t           stb
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             inRange;
  regSel_e          sel;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign inRange = (int'(wordIdx) < NUM_WORDS);

  always_comb begin
    sel = SEL_NONE;
    if (aligned && inRange) begin
      sel = regSel_e'(4'(wordIdx) + 4'd1);
    end
  end

  always_comb begin
    stb.rdSel      = sel;
    stb.wrCs       = wrEn && (sel == SEL_CS);
    stb.wrDescAddr = wrEn && (sel == SEL_DADDR);
    stb.wrDebug    = wrEn && (sel == SEL_DEBUG);
  end

endmodule

// File: rtl/dma_chan_csr_dp.sv
module dma_chan_csr_dp
  import dma_chan_csr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  csrStb_t                      stb,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         descLoad,
  input  logic [DESC_WORDS*DATA_W-1:0] descIn,
  input  logic                         engDone,
  input  logic                         engIntSet,
  output logic [DATA_W-1:0]            rdData,
  output logic                         startPulse,
  output logic                         irqOut
);

  localparam logic [DATA_W-1:0] KEEP_MASK = CS_STORE_MASK | CS_FLAG_MASK;

  logic [DATA_W-1:0] csReg, csNext;
  logic [DATA_W-1:0] descAddr, descAddrNext;
  logic [DATA_W-1:0] debugReg;
  logic [DATA_W-1:0] shadow [DESC_WORDS];
  logic              startNext;

  // Control/status next state: reset first, then W1C, then mask, then engine sets
  always_comb begin
    csNext       = csReg;
    descAddrNext = descAddr;
    if (stb.wrCs) begin
      if (wrData[BIT_RESET]) begin
        csNext       = '0;
        descAddrNext = '0;
      end
      if (wrData[BIT_END]) csNext[BIT_END] = 1'b0;
      if (wrData[BIT_INT]) csNext[BIT_INT] = 1'b0;
      csNext = (csNext & ~CS_STORE_MASK) | (wrData & CS_STORE_MASK);
    end
    if (stb.wrDescAddr) descAddrNext = wrData;
    if (engDone)   csNext[BIT_END] = 1'b1;
    if (engIntSet) csNext[BIT_INT] = 1'b1;
  end

  assign startNext = stb.wrCs && !csReg[BIT_ACTIVE] && wrData[BIT_ACTIVE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csReg      <= '0;
      descAddr   <= '0;
      debugReg   <= '0;
      startPulse <= 1'b0;
    end else begin
      csReg      <= csNext;
      descAddr   <= descAddrNext;
      startPulse <= startNext;
      if (stb.wrDebug) debugReg <= wrData;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN)         shadow[g] <= '0;
      else if (descLoad) shadow[g] <= descIn[g*DATA_W +: DATA_W];
    end

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !descLoad |=> $stable(shadow[g]))
      else $error("shadow word changed without load");
  end

  assign irqOut = csReg[BIT_INT];

  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      SEL_CS:     rdData = csReg;
      SEL_DADDR:  rdData = descAddr;
      SEL_INFO:   rdData = shadow[0];
      SEL_SRC:    rdData = shadow[1];
      SEL_DST:    rdData = shadow[2];
      SEL_LEN:    rdData = shadow[3];
      SEL_STRIDE: rdData = shadow[4];
      SEL_NEXT:   rdData = shadow[5];
      SEL_DEBUG:  rdData = debugReg;
      default:    rdData = '0;
    endcase
  end

  p_end_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCs && wrData[BIT_END] && !engDone |=> !csReg[BIT_END])
    else $error("end flag not cleared");

  p_int_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCs && wrData[BIT_INT] && !engIntSet |=> !irqOut)
    else $error("interrupt line not dropped");

  p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCs && wrData[BIT_RESET] |=> (descAddr == '0) && ((csReg & ~KEEP_MASK) == '0))
    else $error("soft reset left state");

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrCs && wrData[BIT_RESET]) |=> ((csReg & ~KEEP_MASK) == ($past(csReg) & ~KEEP_MASK)))
    else $error("unmasked bit changed");

  p_start_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> csReg[BIT_ACTIVE] && !$past(csReg[BIT_ACTIVE]))
    else $error("start without 0-to-1 edge");

  p_undef_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == SEL_NONE) |-> (rdData == '0))
    else $error("undefined offset read nonzero");

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    engIntSet |=> irqOut && csReg[BIT_INT])
    else $error("interrupt set lost");

  p_done_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    engDone |=> csReg[BIT_END])
    else $error("completion set lost");

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_chan_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              descLoad,
  input  logic [31:0]       descInfo,
  input  logic [31:0]       descSrc,
  input  logic [31:0]       descDst,
  input  logic [31:0]       descLen,
  input  logic [31:0]       descStride,
  input  logic [31:0]       descNext,
  input  logic              engDone,
  input  logic              engIntSet,
  output logic              startPulse,
  output logic              irqOut
);

  csrStb_t stb;
  logic [DESC_WORDS*DATA_W-1:0] descIn;

  assign descIn = {descNext, descStride, descLen, descDst, descSrc, descInfo};

  dma_chan_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  dma_chan_csr_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .descLoad   (descLoad),
    .descIn     (descIn),
    .engDone    (engDone),
    .engIntSet  (engIntSet),
    .rdData     (rdData),
    .startPulse (startPulse),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/dma_chan_csr_bench.sv
`timescale 1ns/1ps
module dma_chan_csr_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        descLoad = 1'b0;
  logic [31:0] descInfo = '0, descSrc = '0, descDst = '0;
  logic [31:0] descLen = '0, descStride = '0, descNext = '0;
  logic        engDone = 1'b0, engIntSet = 1'b0;
  logic        startPulse, irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_chan_csr u_dma_chan_csr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .descLoad(descLoad), .descInfo(descInfo),
    .descSrc(descSrc), .descDst(descDst), .descLen(descLen),
    .descStride(descStride), .descNext(descNext), .engDone(engDone),
    .engIntSet(engIntSet), .startPulse(startPulse), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic eDone = 1'b0, input logic eInt = 1'b0);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; engDone = eDone; engIntSet = eInt;
    @(negedge clk);
    wrEn = 1'b0; engDone = 1'b0; engIntSet = 1'b0;
  endtask

  task automatic eng(input logic eDone, input logic eInt);
    @(negedge clk);
    engDone = eDone; engIntSet = eInt;
    @(negedge clk);
    engDone = 1'b0; engIntSet = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic softReset();
    wr(8'h00, 32'h8000_0000);
  endtask

  task automatic t_reset_r1();
    for (int i = 0; i <= 8; i++) rd(8'(i * 4), 32'h0, "R1 reset read");
    check("R1 irq", 32'(irqOut), 32'h0);
    check("R1 start", 32'(startPulse), 32'h0);
  endtask

  task automatic t_regs_r10();
    wr(8'h04, 32'hDEAD_BEEC);
    rd(8'h04, 32'hDEAD_BEEC, "R10 descriptor pointer");
    wr(8'h20, 32'h5A5A_1234);
    rd(8'h20, 32'h5A5A_1234, "R10 debug word");
  endtask

  task automatic t_desc_r9();
    @(negedge clk);
    descInfo = 32'h1111_0001; descSrc = 32'h2222_0002; descDst = 32'h3333_0003;
    descLen = 32'h4444_0004; descStride = 32'h5555_0005; descNext = 32'h6666_0006;
    descLoad = 1'b1;
    @(negedge clk);
    descLoad = 1'b0;
    rd(8'h08, 32'h1111_0001, "R9 info");
    rd(8'h0C, 32'h2222_0002, "R9 source");
    rd(8'h10, 32'h3333_0003, "R9 destination");
    rd(8'h14, 32'h4444_0004, "R9 length");
    rd(8'h18, 32'h5555_0005, "R9 stride");
    rd(8'h1C, 32'h6666_0006, "R9 next");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h2222_0002, "R9 write ignored");
  endtask

  task automatic t_mask_r5();
    softReset();
    wr(8'h00, 32'h0000_0130);
    rd(8'h00, 32'h0000_0000, "R5 bits 4/5/8 not stored");
    wr(8'h00, 32'h7FFF_FFFE);
    rd(8'h00, 32'h30FF_0000, "R5 masked store");
    check("R5 no start", 32'(startPulse), 32'h0);
    wr(8'h00, 32'h4000_0000);
    rd(8'h00, 32'h0000_0000, "R5 abort no effect");
    wr(8'h00, 32'hFFFF_FFFF);
    check("R6 start on full write", 32'(startPulse), 32'h1);
    rd(8'h00, 32'h30FF_0001, "R5 all-ones write");
  endtask

  task automatic t_start_r6();
    softReset();
    wr(8'h00, 32'h0000_0001);
    check("R6 pulse", 32'(startPulse), 32'h1);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(startPulse), 32'h0);
    wr(8'h00, 32'h0000_0001);
    check("R6 no pulse when active", 32'(startPulse), 32'h0);
    wr(8'h00, 32'h0000_0000);
    check("R6 no pulse on clear", 32'(startPulse), 32'h0);
    wr(8'h00, 32'h0000_0001);
    check("R6 pulse again", 32'(startPulse), 32'h1);
  endtask

  task automatic t_end_r2();
    softReset();
    eng(1'b1, 1'b0);
    rd(8'h00, 32'h0000_0002, "R2 end set");
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, 32'h0000_0002, "R2 zero keeps end");
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, 32'h0000_0000, "R2 end cleared");
  endtask

  task automatic t_int_r3();
    softReset();
    eng(1'b0, 1'b1);
    check("R3 irq raised", 32'(irqOut), 32'h1);
    rd(8'h00, 32'h0000_0004, "R3 int flag");
    wr(8'h00, 32'h0000_0002);
    check("R3 irq kept", 32'(irqOut), 32'h1);
    wr(8'h00, 32'h0000_0004);
    check("R3 irq dropped", 32'(irqOut), 32'h0);
    rd(8'h00, 32'h0000_0000, "R3 flag cleared");
  endtask

  task automatic t_rst_r4();
    softReset();
    wr(8'h00, 32'h0000_0001);
    wr(8'h04, 32'h0000_1000);
    eng(1'b1, 1'b0);
    wr(8'h00, 32'h8001_0000);
    check("R4 no start", 32'(startPulse), 32'h0);
    rd(8'h00, 32'h0001_0000, "R4 cs after reset write");
    rd(8'h04, 32'h0000_0000, "R4 pointer zeroed");
    wr(8'h00, 32'h8000_0001);
    check("R4 start after reset", 32'(startPulse), 32'h1);
    rd(8'h00, 32'h0000_0001, "R4 reset then active");
  endtask

  task automatic t_prio_r8();
    softReset();
    eng(1'b1, 1'b1);
    wr(8'h00, 32'h0000_0006, 1'b1, 1'b1);
    rd(8'h00, 32'h0000_0006, "R8 set wins");
    check("R8 irq kept", 32'(irqOut), 32'h1);
    wr(8'h00, 32'h0000_0006);
    rd(8'h00, 32'h0000_0000, "R8 later clear");
  endtask

  task automatic t_undef_r7();
    softReset();
    wr(8'h04, 32'h1111_2220);
    wr(8'h20, 32'h0000_0033);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h24, 32'h0, "R7 read past end");
    rd(8'h02, 32'h0, "R7 unaligned read");
    rd(8'hF0, 32'h0, "R7 high offset read");
    rd(8'h00, 32'h0, "R7 cs untouched");
    rd(8'h04, 32'h1111_2220, "R7 pointer untouched");
    rd(8'h20, 32'h0000_0033, "R7 debug untouched");
    check("R7 no start", 32'(startPulse), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_regs_r10();
    t_desc_r9();
    t_mask_r5();
    t_start_r6();
    t_end_r2();
    t_int_r3();
    t_rst_r4();
    t_prio_r8();
    t_undef_r7();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule